// File: doc/BRIEF.md
# Windowed Two-Term Sequence Matcher

This block watches two boolean conditions on every clock and reports when a start condition is followed, some number of cycles later, by a second condition. The number of cycles between the two events is limited to a window [MIN:MAX], set at elaboration. Setting MIN equal to MAX turns the window into an exact delay. The block is meant to sit beside a design as a passive monitor. Its match outputs feed a checker or a coverage counter further down the line.

Every start event opens an attempt. Each attempt is kept in an age pipeline with one stage per cycle of age, from age 0 up to age MAX, so many attempts can be pending at the same time. Two run-time selects set how the second condition is consumed. The semantics select chooses between reporting every in-window hit and finishing an attempt on its first hit. The arbitration select chooses between serving every pending attempt at once (overlap) and serving only the oldest one (pipe). An attempt that reaches the end of its window without a hit is dropped without any report.

Top module: `seqwin_match`

## Requirements
- R1: An attempt opens in a cycle where `enable_i` and `start_i` are both 1. If `cond_i` is 1 (with `enable_i` 1) k cycles later, where MIN <= k <= MAX and k = 0 is the start cycle itself, that attempt is satisfied. All outputs are registered, so `match_o` goes high on the clock edge that ends the cycle of the hit. When `cond_i` is 0 in a cycle, `match_o` is 0 in the next cycle.
- R2: When MIN equals MAX, an attempt can be satisfied only at exactly that offset.
- R3: With `first_sel_i` = 0 (all-matches), every in-window cycle with `cond_i` = 1 satisfies the attempt again. A start followed by three cycles of `cond_i`, with MIN=1 and MAX>=3, gives three match pulses.
- R4: With `first_sel_i` = 1 (first-match), an attempt retires on its first satisfying cycle and gives no later match. In this mode `first_o` equals `match_o`.
- R5: With `pipe_sel_i` = 0 (overlap), one hit satisfies every pending attempt whose window covers that cycle. `match_cnt_o` is the number of attempts satisfied, and `match_o` is 1 exactly when that number is nonzero.
- R6: With `pipe_sel_i` = 1 (pipe), one hit satisfies only the oldest eligible attempt. `match_cnt_o` is then at most 1.
- R7: Up to MAX+1 attempts, one of each age from 0 to MAX, are tracked at the same time.
- R8: An attempt older than MAX is dropped silently. A hit before MIN or after MAX gives no match, and `match_cnt_o` never exceeds MAX-MIN+1.
- R9: Reset (`rst_ni` = 0, asynchronous) clears all pending attempts and holds every output at 0.
- R10: While `enable_i` = 0, no attempt opens and no hit is counted, and the next cycle's outputs are 0. Pending attempts keep aging during this time.
- R11: `first_o` pulses when at least one attempt is satisfied for the first time. When the parameter HAS_FIRST = 0, `first_o` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Qualifies both start events and hits |
| start_i | input | 1 | Start condition |
| cond_i | input | 1 | Second condition |
| first_sel_i | input | 1 | 0 all-matches, 1 first-match |
| pipe_sel_i | input | 1 | 0 overlap, 1 pipe (oldest only) |
| match_o | output | 1 | At least one attempt satisfied in the previous cycle |
| match_cnt_o | output | $clog2(MAX+2) | Number of attempts satisfied in the previous cycle |
| first_o | output | 1 | An attempt was satisfied for the first time |

## Verification
The embedded properties compare each cycle's outputs with the inputs of the previous cycle. They therefore assume that `enable_i`, `cond_i`, `pipe_sel_i` and `first_sel_i` are valid, known levels on every clock edge after reset. The stimulus drives all inputs on the falling edge, from reset onward, and never leaves them undefined. The selects may change on any cycle, and the reference model applies the select values of the current cycle, exactly as the block does. Mode changes in the random phase therefore stay inside that assumption, including switches made while attempts are already marked as matched.

// File: rtl/seqwin_pkg.sv
package seqwin_pkg;

   // Largest window end the block accepts.
   localparam int unsigned SEQWIN_MAX_LIMIT = 63;

   // How a hit is consumed by an attempt.
   typedef enum logic {
      SEM_ALL   = 1'b0,
      SEM_FIRST = 1'b1
   } sem_e;

   // Which pending attempts one hit serves.
   typedef enum logic {
      ARB_OVERLAP = 1'b0,
      ARB_PIPE    = 1'b1
   } arb_e;

   function automatic int unsigned cnt_width(input int unsigned max_age);
      return $clog2(max_age + 2);
   endfunction

endpackage

// File: rtl/seqwin_age_pipe.sv
module seqwin_age_pipe #(
   parameter int unsigned AGES = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            open_i,
   input  logic [AGES-1:0] retire_i,
   input  logic [AGES-1:0] mark_i,
   output logic [AGES-1:0] live_v_o,
   output logic [AGES-1:0] live_m_o
);

   // Age 0 comes straight from the start condition; ages 1..AGES-1 are stored.
   assign live_v_o[0] = open_i;
   assign live_m_o[0] = 1'b0;

   generate
      if (AGES > 1) begin : g_store
         localparam int unsigned SLOTS = AGES - 1;
         logic [SLOTS-1:0] v_q;
         logic [SLOTS-1:0] m_q;

         for (genvar k = 0; k < SLOTS; k++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  v_q[k] <= 1'b0;
                  m_q[k] <= 1'b0;
               end else begin
                  v_q[k] <= live_v_o[k] & ~retire_i[k];
                  m_q[k] <= (live_m_o[k] | mark_i[k]) & live_v_o[k] & ~retire_i[k];
               end
            end
            assign live_v_o[k+1] = v_q[k];
            assign live_m_o[k+1] = m_q[k];
         end

         // An age-1 attempt exists only if a start was seen one cycle earlier.
         p_fresh_attempt_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            !open_i |=> !live_v_o[1]);

         // A marked attempt is always a live attempt.
         p_mark_live_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (live_m_o & ~live_v_o) == '0);
      end
   endgenerate

endmodule

// File: rtl/seqwin_oldest.sv
module seqwin_oldest #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o
);

   // Highest index wins: the highest age is the oldest attempt.
   always_comb begin
      gnt_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i]) begin
            gnt_o = '0;
            gnt_o[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/seqwin_popcnt.sv
module seqwin_popcnt #(
   parameter int unsigned N = 4,
   parameter int unsigned W = 3
) (
   input  logic [N-1:0] bits_i,
   output logic [W-1:0] cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < N; i++) begin
         cnt_o = cnt_o + W'(bits_i[i]);
      end
   end

endmodule

// File: rtl/seqwin_match.sv
module seqwin_match
   import seqwin_pkg::*;
#(
   parameter int unsigned MIN       = 1,
   parameter int unsigned MAX       = 4,
   parameter bit          HAS_FIRST = 1'b1,
   localparam int unsigned AGES     = MAX + 1,
   localparam int unsigned CW       = cnt_width(MAX)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          enable_i,
   input  logic          start_i,
   input  logic          cond_i,
   input  logic          first_sel_i,
   input  logic          pipe_sel_i,
   output logic          match_o,
   output logic [CW-1:0] match_cnt_o,
   output logic          first_o
);

   // Elaboration-time parameter checks.
   generate
      if (MIN > MAX) begin : g_bad_window
         $error("seqwin_match: MIN must not exceed MAX");
      end
      if (MAX > SEQWIN_MAX_LIMIT) begin : g_bad_max
         $error("seqwin_match: MAX above supported limit");
      end
   endgenerate

   sem_e sem;
   arb_e arb;
   assign sem = sem_e'(first_sel_i);
   assign arb = arb_e'(pipe_sel_i);

   logic [AGES-1:0] live_v, live_m;
   logic [AGES-1:0] in_win, cand, oldest, sel, retire;
   logic [CW-1:0]   sel_cnt;
   logic            hit_en, first_hit;

   // Window mask: ages MIN..MAX may take a hit.
   generate
      for (genvar k = 0; k < AGES; k++) begin : g_win
         assign in_win[k] = (k >= MIN);
      end
   endgenerate

   assign hit_en = enable_i & cond_i;

   always_comb begin
      cand = live_v & in_win & {AGES{hit_en}};
      if (sem == SEM_FIRST) cand = cand & ~live_m;
   end

   seqwin_oldest #(.N(AGES)) u_oldest (
      .req_i (cand),
      .gnt_o (oldest)
   );

   assign sel    = (arb == ARB_PIPE) ? oldest : cand;
   assign retire = (sem == SEM_FIRST) ? sel : '0;

   seqwin_age_pipe #(.AGES(AGES)) u_pipe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .open_i   (enable_i & start_i),
      .retire_i (retire),
      .mark_i   (sel),
      .live_v_o (live_v),
      .live_m_o (live_m)
   );

   seqwin_popcnt #(.N(AGES), .W(CW)) u_cnt (
      .bits_i (sel),
      .cnt_o  (sel_cnt)
   );

   generate
      if (HAS_FIRST) begin : g_first
         assign first_hit = |(sel & ~live_m);
      end else begin : g_no_first
         assign first_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         match_o     <= 1'b0;
         match_cnt_o <= '0;
         first_o     <= 1'b0;
      end else begin
         match_o     <= |sel;
         match_cnt_o <= sel_cnt;
         first_o     <= first_hit;
      end
   end

   // ---------------- assertions ----------------
   p_needs_cond_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cond_i |=> !match_o);

   p_quiet_disabled_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (!match_o && match_cnt_o == '0 && !first_o));

   p_count_agrees_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o == (match_cnt_o != '0));

   p_pipe_single_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      pipe_sel_i |=> (match_cnt_o <= CW'(1)));

   p_pick_onehot_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(oldest));

   p_cnt_bound_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_cnt_o <= CW'(MAX - MIN + 1));

   p_first_implies_match_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      first_o |-> match_o);

   generate
      if (HAS_FIRST) begin : g_first_chk
         p_first_once_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            first_sel_i |=> (first_o == match_o));
      end else begin : g_nofirst_chk
         p_first_tied_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            !first_o);
      end
   endgenerate

endmodule

// File: tb/seqwin_match_test.sv
`timescale 1ns/100ps

module seqwin_match_ref #(
   parameter int MIN = 1,
   parameter int MAX = 4,
   parameter bit HAS_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start,
   input  logic cond,
   input  logic first_sel,
   input  logic pipe_sel,
   output logic exp_match,
   output int   exp_cnt,
   output logic exp_first
);
   int age[$];
   bit mk[$];

   initial begin
      exp_match = 0; exp_cnt = 0; exp_first = 0;
   end

   always @(posedge clk) begin : step
      int na[$];
      bit nm[$];
      bit s[$];
      bit done;
      int cnt;
      bit f;
      if (!rst_n) begin
         age.delete(); mk.delete();
         exp_match = 0; exp_cnt = 0; exp_first = 0;
      end else begin
         if (en && start) begin age.push_back(0); mk.push_back(0); end
         s.delete(); na.delete(); nm.delete();
         done = 0; cnt = 0; f = 0;
         for (int i = 0; i < age.size(); i++) begin
            bit c;
            c = en && cond && age[i] >= MIN && age[i] <= MAX && (!first_sel || !mk[i]);
            if (pipe_sel) begin
               s.push_back(c && !done);
               if (c) done = 1;
            end else s.push_back(c);
         end
         for (int i = 0; i < age.size(); i++) begin
            if (s[i]) begin cnt++; if (!mk[i]) f = 1; end
            if (!(s[i] && first_sel) && age[i] + 1 <= MAX) begin
               na.push_back(age[i] + 1);
               nm.push_back(mk[i] | s[i]);
            end
         end
         age = na; mk = nm;
         exp_cnt = cnt; exp_match = (cnt != 0); exp_first = HAS_FIRST && f;
      end
   end
endmodule

module seqwin_match_test;
   localparam real HALF = 2.5;
   localparam int  CW1  = $clog2(4 + 2);
   localparam int  CW2  = $clog2(2 + 2);

   logic clk = 0;
   logic rst_n = 0;
   logic en = 0, start = 0, cond = 0, fsel = 0, psel = 0;
   logic m1, f1, m2, f2;
   logic [CW1-1:0] c1;
   logic [CW2-1:0] c2;
   logic em1, ef1, em2, ef2;
   int   ec1, ec2;

   int checks = 0, errors = 0;
   string cur_req = "R9";
   bit mon_on = 0;
   int tot_m, tot_first, tot_fix, tot_fix_first, mx_cnt;

   always #(HALF) clk = ~clk;

   seqwin_match #(.MIN(1), .MAX(4), .HAS_FIRST(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_i(start), .cond_i(cond),
      .first_sel_i(fsel), .pipe_sel_i(psel),
      .match_o(m1), .match_cnt_o(c1), .first_o(f1));

   seqwin_match #(.MIN(2), .MAX(2), .HAS_FIRST(1'b0)) uut_fix (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_i(start), .cond_i(cond),
      .first_sel_i(fsel), .pipe_sel_i(psel),
      .match_o(m2), .match_cnt_o(c2), .first_o(f2));

   seqwin_match_ref #(.MIN(1), .MAX(4), .HAS_FIRST(1'b1)) ref1 (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cond(cond),
      .first_sel(fsel), .pipe_sel(psel),
      .exp_match(em1), .exp_cnt(ec1), .exp_first(ef1));

   seqwin_match_ref #(.MIN(2), .MAX(2), .HAS_FIRST(1'b0)) ref2 (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cond(cond),
      .first_sel(fsel), .pipe_sel(psel),
      .exp_match(em2), .exp_cnt(ec2), .exp_first(ef2));

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the reference models.
   always @(negedge clk) begin
      if (mon_on) begin
         check(cur_req, "uut match", int'(m1), int'(em1));
         check(cur_req, "uut count", int'(c1), ec1);
         check(cur_req, "uut first", int'(f1), int'(ef1));
         check(cur_req, "fix match", int'(m2), int'(em2));
         check(cur_req, "fix count", int'(c2), ec2);
         check(cur_req, "fix first", int'(f2), int'(ef2));
         tot_m += int'(m1);
         tot_first += int'(f1);
         tot_fix += int'(m2);
         tot_fix_first += int'(f2);
         if (int'(c1) > mx_cnt) mx_cnt = int'(c1);
      end
   end

   task automatic cyc(input logic s, input logic c);
      @(negedge clk); #1;
      start = s; cond = c;
   endtask

   task automatic clear_stats();
      @(negedge clk); #1;
      tot_m = 0; tot_first = 0; tot_fix = 0; tot_fix_first = 0; mx_cnt = 0;
   endtask

   task automatic flush();
      for (int i = 0; i < 7; i++) cyc(0, 0);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(HALF * 2 * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      tot_m = 0; tot_first = 0; tot_fix = 0; tot_fix_first = 0; mx_cnt = 0;
      repeat (3) @(negedge clk);
      // R9: outputs low while in reset
      check("R9", "match in reset", int'(m1), 0);
      check("R9", "count in reset", int'(c1), 0);
      check("R9", "first in reset", int'(f1), 0);
      #1; rst_n = 1; en = 1;
      mon_on = 1;

      // R3 all-matches overlap; R2 fixed delay; R11 first pulse once
      cur_req = "R3"; clear_stats();
      cyc(1, 0); cyc(0, 1); cyc(0, 1); cyc(0, 1); flush();
      check("R3", "three matches", tot_m, 3);
      check("R11", "first pulses", tot_first, 1);
      check("R2", "fixed delay hits once", tot_fix, 1);

      // R4 first-match
      cur_req = "R4"; fsel = 1; clear_stats();
      cyc(1, 0); cyc(0, 1); cyc(0, 1); cyc(0, 1); flush();
      check("R4", "single match", tot_m, 1);
      check("R11", "fix first tied low", tot_fix_first, 0);
      fsel = 0;

      // R5 overlap: two pending attempts served by one hit
      cur_req = "R5"; clear_stats();
      cyc(1, 0); cyc(1, 0); cyc(0, 1); flush();
      check("R5", "overlap count", mx_cnt, 2);

      // R6 pipe: only the oldest
      cur_req = "R6"; psel = 1; clear_stats();
      cyc(1, 0); cyc(1, 0); cyc(0, 1); flush();
      check("R6", "pipe count", mx_cnt, 1);
      check("R6", "pipe matches", tot_m, 1);
      psel = 0;

      // R7 five attempts in flight
      cur_req = "R7"; clear_stats();
      cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 1); flush();
      check("R7", "concurrent count", mx_cnt, 4);

      // R8 hits outside the window
      cur_req = "R8"; clear_stats();
      cyc(1, 1); cyc(0, 0); cyc(0, 0); cyc(0, 0); cyc(0, 0); cyc(0, 1); flush();
      check("R8", "no match outside window", tot_m, 0);
      check("R8", "fix no match", tot_fix, 0);

      // R10 enable low blocks starts and hits, aging continues
      cur_req = "R10"; clear_stats();
      @(negedge clk); #1; en = 0; start = 1;
      cyc(0, 1); cyc(0, 1); cyc(0, 1);
      @(negedge clk); #1; en = 1; start = 0; cond = 0;
      flush();
      check("R10", "disabled no match", tot_m, 0);
      clear_stats();
      cyc(1, 0);
      @(negedge clk); #1; en = 0; start = 0;
      @(negedge clk); #1; en = 1; cond = 1;
      cyc(0, 0); flush();
      check("R10", "attempt aged through disable", tot_m, 1);

      // R9 reset clears pending attempts
      cur_req = "R9"; clear_stats();
      cyc(1, 0);
      @(negedge clk); #1; rst_n = 0; start = 0;
      @(negedge clk); #1; rst_n = 1;
      cyc(0, 1); cyc(0, 1); flush();
      check("R9", "reset flushes attempts", tot_m, 0);

      // R1 random traffic in all mode combinations
      cur_req = "R1";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk); #1;
         start = ($urandom_range(0, 2) == 0);
         cond  = ($urandom_range(0, 2) == 0);
         en    = ($urandom_range(0, 9) != 0);
         if (i % 200 == 0) begin
            fsel = $urandom_range(0, 1);
            psel = $urandom_range(0, 1);
         end
      end
      cyc(0, 0); flush();
      summary();
   end
endmodule